// File: doc/BRIEF.md
# Chunked Flash Read-Back Streamer

This block serves a host that wants to read back the full contents of a flash array. Each host request carries a command code and one argument byte. A valid request makes the block send one chunk on a byte-stream output. A chunk holds up to a fixed number of data bytes, followed by a 16-bit CRC over those bytes. The argument either moves on to the next chunk or asks for the chunk just sent to be sent again, byte for byte.

The block keeps two pointers: where the next chunk begins, and where the last chunk began. It fetches data through a synchronous read port that has one cycle of latency. It sends one byte per cycle with no gaps, and marks the final CRC byte. When fewer bytes than a full chunk remain at the top of memory, the chunk is shortened. Once memory is used up, a chunk carries only its CRC. The transport that carries the bytes, and the flash device itself, are outside the block.

Top module: `flash_readback_streamer`

## Requirements
- R1: After reset `outValid` and `busy` are low. The next-chunk pointer and the last-chunk start are both address 0.
- R2: A request is accepted only when `busy` is low, `reqCode` is 0x37 and `reqArg` is 0x00 or 0x01. Any other request produces no output and leaves `busy` low.
- R3: An accepted request produces a contiguous burst, one byte per cycle: first the data bytes, then the CRC low byte, then the CRC high byte. `outLast` is high only with the CRC high byte. The first byte appears at the outputs two clock edges after the accepting edge.
- R4: The CRC uses polynomial 0x1021, shifted in MSB first with no reflection and no final inversion. It is seeded to 0xFFFF at the start of every chunk and covers only that chunk's data bytes.
- R5: Argument 0x01 (next) starts at the next-chunk pointer. It sends min(CHUNK_MAX, MEM_DEPTH - start) bytes from consecutive addresses, so the final chunk is shortened. No read is issued at or beyond MEM_DEPTH.
- R6: A next request once memory is used up sends zero data bytes and the CRC bytes 0xFF, 0xFF. Repeating it gives the same result.
- R7: Argument 0x00 (resend) replays the chunk that began at the last-chunk start. A resend before any chunk has been sent returns the first chunk, and a following next returns the second chunk.
- R8: A request that arrives while `busy` is high is ignored. It neither changes the burst in progress nor moves either pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one cycle |
| reqCode | input | 8 | Command code; 0x37 selects read-back |
| reqArg | input | 8 | 0x00 resend previous chunk, 0x01 send next chunk |
| busy | output | 1 | A chunk is being streamed; requests are ignored |
| memRdEn | output | 1 | Read enable to the synchronous memory |
| memAddr | output | MEM_AW | Read address |
| memRdData | input | 8 | Read data, valid the cycle after memRdEn |
| outValid | output | 1 | Output byte valid |
| outData | output | 8 | Output byte |
| outLast | output | 1 | Marks the CRC high byte, the final byte of a chunk |

## Verification
Several properties are checked on every cycle. Memory reads never leave the array and the pointers never pass its end. The CRC high byte always follows the CRC low byte. No chunk carries more than the maximum number of data bytes. `outLast` comes only with `outValid`, and a burst ends only on its last byte. The bench's scenarios are needed for the rest: exact byte values and CRC, the start latency, the shortened and empty final chunks, resend before and after chunks, and requests that must be ignored, whether malformed or arriving while busy. Its cycle-accurate model checks these on every clock.

// File: rtl/frs_pkg.sv
package frs_pkg;

  localparam logic [7:0] CMD_READBACK = 8'h37;
  localparam logic [7:0] ARG_RESEND   = 8'h00;
  localparam logic [7:0] ARG_NEXT     = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TAIL,
    ST_CRCL,
    ST_CRCH
  } frs_state_t;

  // control -> datapath strobes
  typedef struct packed {
    logic load;       // request accepted this cycle
    logic useLast;    // replay from last-chunk start
    logic rdEn;       // issue one memory read
    logic emitData;   // memory data valid, send it
    logic emitCrcLo;
    logic emitCrcHi;
  } frs_strobe_t;

  // one byte through the x^16+x^12+x^5+1 register, MSB first
  function automatic logic [15:0] crcStep(input logic [15:0] cur, input logic [7:0] din);
    logic [15:0] r;
    r = cur ^ {din, 8'h00};
    for (int i = 0; i < 8; i++) begin
      r = r[15] ? ({r[14:0], 1'b0} ^ 16'h1021) : {r[14:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/frs_ctrl.sv
module frs_ctrl
  import frs_pkg::*;
#(
  parameter int CHUNK_MAX = 251,
  parameter int LEN_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [7:0]       reqCode,
  input  logic [7:0]       reqArg,
  input  logic [LEN_W-1:0] candLen,
  output frs_strobe_t      strobe,
  output logic             busy
);

  frs_state_t       state;
  logic [LEN_W-1:0] remain;
  logic             pend;
  logic             accept;

  assign accept = reqValid && (state == ST_IDLE) && (reqCode == CMD_READBACK)
                  && ((reqArg == ARG_RESEND) || (reqArg == ARG_NEXT));

  always_comb begin
    strobe           = '0;
    strobe.load      = accept;
    strobe.useLast   = (reqArg == ARG_RESEND);
    strobe.rdEn      = (state == ST_READ);
    strobe.emitData  = pend;
    strobe.emitCrcLo = (state == ST_CRCL);
    strobe.emitCrcHi = (state == ST_CRCH);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      remain <= '0;
      pend   <= 1'b0;
    end else begin
      pend <= strobe.rdEn;
      unique case (state)
        ST_IDLE: if (accept) begin
          remain <= candLen;
          state  <= (candLen == '0) ? ST_TAIL : ST_READ;
        end
        ST_READ: begin
          remain <= remain - LEN_W'(1);
          if (remain == LEN_W'(1)) state <= ST_TAIL;
        end
        ST_TAIL: state <= ST_CRCL;
        ST_CRCL: state <= ST_CRCH;
        ST_CRCH: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // per-chunk data byte counter for the checks below
  logic [LEN_W:0] byteCnt;
  always_ff @(posedge clk) begin
    if (!rstN)               byteCnt <= '0;
    else if (strobe.load)    byteCnt <= '0;
    else if (strobe.emitData) byteCnt <= byteCnt + (LEN_W+1)'(1);
  end

  // R3
  crc_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emitCrcLo |=> strobe.emitCrcHi);

  // R3
  chunk_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emitCrcLo |-> (byteCnt <= (LEN_W+1)'(CHUNK_MAX)));

endmodule

// File: rtl/frs_datapath.sv
module frs_datapath
  import frs_pkg::*;
#(
  parameter int MEM_DEPTH = 600,
  parameter int CHUNK_MAX = 251,
  parameter int PTR_W     = 10,
  parameter int LEN_W     = 8,
  parameter int MEM_AW    = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  frs_strobe_t       strobe,
  output logic [LEN_W-1:0]  candLen,
  output logic              memRdEn,
  output logic [MEM_AW-1:0] memAddr,
  input  logic [7:0]        memRdData,
  output logic              outValid,
  output logic [7:0]        outData,
  output logic              outLast
);

  localparam int CMP_W = (PTR_W > LEN_W) ? PTR_W : LEN_W;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(MEM_DEPTH);
  localparam logic [CMP_W-1:0] CHUNK_W = CMP_W'(CHUNK_MAX);

  logic [PTR_W-1:0] nextPtr, lastStart, rdAddr, selStart;
  logic [CMP_W-1:0] roomW, lenW;
  logic [15:0]      crc;

  always_comb begin
    selStart = strobe.useLast ? lastStart : nextPtr;
    roomW    = CMP_W'(DEPTH_P - selStart);
    lenW     = (roomW > CHUNK_W) ? CHUNK_W : roomW;
    candLen  = lenW[LEN_W-1:0];
  end

  assign memRdEn = strobe.rdEn;
  assign memAddr = rdAddr[MEM_AW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPtr   <= '0;
      lastStart <= '0;
      rdAddr    <= '0;
      crc       <= 16'hFFFF;
    end else if (strobe.load) begin
      lastStart <= selStart;
      nextPtr   <= selStart + lenW[PTR_W-1:0];
      rdAddr    <= selStart;
      crc       <= 16'hFFFF;
    end else begin
      if (strobe.rdEn)     rdAddr <= rdAddr + PTR_W'(1);
      if (strobe.emitData) crc    <= crcStep(crc, memRdData);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outLast  <= 1'b0;
    end else begin
      outValid <= strobe.emitData | strobe.emitCrcLo | strobe.emitCrcHi;
      outLast  <= strobe.emitCrcHi;
      if (strobe.emitData)       outData <= memRdData;
      else if (strobe.emitCrcLo) outData <= crc[7:0];
      else if (strobe.emitCrcHi) outData <= crc[15:8];
    end
  end

  // R5
  addr_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (rdAddr < DEPTH_P));

  // R6
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nextPtr <= DEPTH_P) && (lastStart <= DEPTH_P));

endmodule

// File: rtl/flash_readback_streamer.sv
module flash_readback_streamer
  import frs_pkg::*;
#(
  parameter int  MEM_DEPTH = 600,
  parameter int  CHUNK_MAX = 251,
  localparam int MEM_AW    = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [7:0]        reqCode,
  input  logic [7:0]        reqArg,
  output logic              busy,
  output logic              memRdEn,
  output logic [MEM_AW-1:0] memAddr,
  input  logic [7:0]        memRdData,
  output logic              outValid,
  output logic [7:0]        outData,
  output logic              outLast
);

  localparam int PTR_W = $clog2(MEM_DEPTH + 1);
  localparam int LEN_W = $clog2(CHUNK_MAX + 1);

  frs_strobe_t      strobe;
  logic [LEN_W-1:0] candLen;

  frs_ctrl #(
    .CHUNK_MAX(CHUNK_MAX),
    .LEN_W    (LEN_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqCode (reqCode),
    .reqArg  (reqArg),
    .candLen (candLen),
    .strobe  (strobe),
    .busy    (busy)
  );

  frs_datapath #(
    .MEM_DEPTH(MEM_DEPTH),
    .CHUNK_MAX(CHUNK_MAX),
    .PTR_W    (PTR_W),
    .LEN_W    (LEN_W),
    .MEM_AW   (MEM_AW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .candLen  (candLen),
    .memRdEn  (memRdEn),
    .memAddr  (memAddr),
    .memRdData(memRdData),
    .outValid (outValid),
    .outData  (outData),
    .outLast  (outLast)
  );

  // R3
  last_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  // R3
  no_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> $past(outLast));

endmodule

// File: tb/flash_readback_streamer_bench.sv
module flash_readback_streamer_bench;

  localparam int DEPTH = 600;
  localparam int CHUNK = 251;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [7:0]    reqCode = '0;
  logic [7:0]    reqArg = '0;
  logic          busy, memRdEn, outValid, outLast;
  logic [AW-1:0] memAddr;
  logic [7:0]    memRdData = '0;
  logic [7:0]    outData;

  always #5 clk = ~clk;

  flash_readback_streamer #(.MEM_DEPTH(DEPTH), .CHUNK_MAX(CHUNK)) u_flash_readback_streamer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCode(reqCode), .reqArg(reqArg),
    .busy(busy), .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .outValid(outValid), .outData(outData), .outLast(outLast)
  );

  function automatic logic [7:0] memVal(input int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  always @(posedge clk) if (memRdEn) memRdData <= memVal(int'(memAddr));

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int startCyc = 0;
  bit done = 0;
  string curTag = "R1";

  logic [7:0] expD[$];
  bit         expL[$];
  bit         expC[$];
  int modelNext = 0;
  int modelLast = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // cycle-accurate comparison against the queued expectation
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (expD.size() > 0 && cyc >= startCyc) begin
        check(outValid === 1'b1 && outData === expD[0] && outLast === expL[0],
              expC[0] ? "R4" : curTag,
              $sformatf("valid=%0b data=%h last=%0b expected valid=1 data=%h last=%0b",
                        outValid, outData, outLast, expD[0], expL[0]));
        void'(expD.pop_front()); void'(expL.pop_front()); void'(expC.pop_front());
      end else begin
        check(outValid === 1'b0, curTag,
              $sformatf("valid=%0b expected valid=0", outValid));
      end
    end
  end

  function automatic logic [15:0] refCrc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int b = 7; b >= 0; b--) begin
      logic fb = r[15] ^ d[b];
      r = r << 1;
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic buildChunk(input bit resend);
    int s = resend ? modelLast : modelNext;
    int n = (DEPTH - s > CHUNK) ? CHUNK : DEPTH - s;
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      logic [7:0] v = memVal(s + i);
      c = refCrc(c, v);
      expD.push_back(v); expL.push_back(1'b0); expC.push_back(1'b0);
    end
    expD.push_back(c[7:0]);  expL.push_back(1'b0); expC.push_back(1'b1);
    expD.push_back(c[15:8]); expL.push_back(1'b1); expC.push_back(1'b1);
    modelLast = s;
    modelNext = s + n;
  endtask

  task automatic sendReq(input logic [7:0] code, input logic [7:0] arg, input bit accepted);
    @(negedge clk);
    reqValid = 1'b1; reqCode = code; reqArg = arg;
    @(negedge clk);
    reqValid = 1'b0;
    if (accepted) begin
      startCyc = cyc + 2;
      buildChunk(arg == 8'h00);
    end
  endtask

  task automatic drain();
    while (expD.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: cycles=%0d expected completion", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(outValid === 1'b0 && busy === 1'b0, "R1",
          $sformatf("valid=%0b busy=%0b expected 0 0", outValid, busy));

    // R7 resend before anything returns the first chunk
    curTag = "R7"; sendReq(8'h37, 8'h00, 1'b1); drain();
    // R7 following next returns the second chunk
    sendReq(8'h37, 8'h01, 1'b1); drain();
    // R7 replay of the second chunk
    sendReq(8'h37, 8'h00, 1'b1); drain();
    // R5 shortened final chunk
    curTag = "R5"; sendReq(8'h37, 8'h01, 1'b1); drain();
    // R6 empty chunks after the end, for next and resend
    curTag = "R6"; sendReq(8'h37, 8'h01, 1'b1); drain();
    sendReq(8'h37, 8'h01, 1'b1); drain();
    sendReq(8'h37, 8'h00, 1'b1); drain();

    // R2 malformed requests are ignored
    curTag = "R2";
    sendReq(8'h36, 8'h01, 1'b0);
    check(busy === 1'b0, "R2", $sformatf("busy=%0b expected 0", busy));
    sendReq(8'h37, 8'h02, 1'b0);
    check(busy === 1'b0, "R2", $sformatf("busy=%0b expected 0", busy));
    sendReq(8'h37, 8'hFF, 1'b0);
    repeat (10) @(negedge clk);

    // R1 reset returns pointers to zero
    rstN = 1'b0; expD.delete(); expL.delete(); expC.delete();
    modelNext = 0; modelLast = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0 && busy === 1'b0, "R1",
          $sformatf("valid=%0b busy=%0b expected 0 0", outValid, busy));
    curTag = "R1"; sendReq(8'h37, 8'h01, 1'b1);

    // R8 request while busy is ignored
    curTag = "R8";
    repeat (20) @(negedge clk);
    check(busy === 1'b1, "R8", $sformatf("busy=%0b expected 1", busy));
    sendReq(8'h37, 8'h01, 1'b0);
    repeat (5) @(negedge clk);
    sendReq(8'h37, 8'h00, 1'b0);
    drain();
    // R8 pointer not moved: next gives the second chunk
    sendReq(8'h37, 8'h01, 1'b1); drain();
    // R4 final-chunk CRC once more via next
    curTag = "R4"; sendReq(8'h37, 8'h01, 1'b1); drain();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule